// File: doc/BRIEF.md
# Teletext Line Insertion Sequencer

This block paces the data-request window and the per-bit sampling of one teletext line in the vertical blanking interval. It runs on a 27 MHz system clock. A line starts on the rising edge of the horizontal sync input. When insertion is enabled at that edge, the block raises a request output for an upstream data source. The source answers after a programmable latency of 0 to 15 clocks. The request opens early by exactly that latency, so the first data bit always arrives at a fixed point 275 clocks (about 10.2 µs) after the sync edge.

From that point the block steps through 360 serial bits (45 bytes). The nominal bit rate of 6.9375 Mbit/s does not divide the clock evenly, so each bit lasts either 3 or 4 clocks. The pattern repeats every 37 bits, and each group of 37 bits takes exactly 144 clocks. The block samples the serial input on the first clock of every bit and presents the sampled value with a one-clock valid strobe. A one-clock completion pulse follows the last bit.

A new sync edge during a line aborts that line and starts timing again from the new edge. Filtering, analog output, register access and the choice of which lines carry teletext are handled elsewhere.

Top module: `txt_line_sequencer`

## Requirements
- R1: While reset is held and right after it, `req_o`, `bit_valid_o` and `line_done_o` are low.
- R2: A clock edge that samples `hsync` high, after it was sampled low, starts a line. Call the cycle after that edge clock 0. `req_o` is high from clock 275−D through clock 275−D+1401, where D is `src_delay`, and is low at every other clock of the line.
- R3: Bit i (0-based) begins at clock 275 plus the summed lengths of bits 0..i−1. Take p = (i mod 37)+1. The bit lasts 3 clocks when p is 10, 19, 28 or 37, and 4 clocks otherwise.
- R4: Every complete group of 37 bits spans 144 clocks. All 360 bits together span 1402 clocks.
- R5: `bit_valid_o` is high for exactly one clock, the clock after each bit begins. It fires 360 times per line. At that clock `bit_o` equals the value of `serial_in` during the bit's first clock.
- R6: `line_done_o` is a one-clock pulse at clock 275+1402 = 1677 of an enabled line that was not aborted.
- R7: When `enable` is low at the starting sync edge, `req_o`, `bit_valid_o` and `line_done_o` stay low for the whole line.
- R8: `enable` and `src_delay` are sampled only at the starting sync edge. Changing them during a line does not change that line's outputs.
- R9: A new sync edge during a line abandons the old line and restarts all timing from the new edge. The old line produces no further strobes and no done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Insertion enable, sampled at the sync edge |
| src_delay | input | 4 | Source latency in clocks (0..15), sampled at the sync edge |
| hsync | input | 1 | Horizontal sync level; the rising edge starts a line |
| serial_in | input | 1 | Serial data from the source |
| req_o | output | 1 | Data request window to the source |
| bit_o | output | 1 | Most recently sampled data bit |
| bit_valid_o | output | 1 | One-clock strobe marking a new `bit_o` |
| line_done_o | output | 1 | One-clock pulse after the 360th bit |

## Verification
A wrong bit-length counter or group position first shows as a strobe spacing of 2, 5, or a 3 placed at the wrong bit. It then shifts every later strobe, so a single group sum that differs from 144 reveals it within about 144 clocks of the fault. A mis-latched delay or a bad window compare moves the edges of `req_o` away from 275−D and 275−D+1402, and this is visible on the very first clock of the window. Broken abort or enable handling shows up as strobes or a done pulse on a line that was abandoned or disabled.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

  // A bit is short when its 1-based position within its group sits on the
  // stride grid that starts at `first`.
  function automatic bit is_short(input int unsigned pos0,
                                  input int unsigned first,
                                  input int unsigned stride);
    int unsigned p1;
    p1 = pos0 + 1;
    return (p1 >= first) && (((p1 - first) % stride) == 0);
  endfunction

  // Clocks needed to carry `nbits` bits with the repeating short/long cadence.
  function automatic int unsigned line_clocks(input int unsigned nbits,
                                              input int unsigned group,
                                              input int unsigned long_c,
                                              input int unsigned first,
                                              input int unsigned stride);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < nbits; i++)
      acc += is_short(i % group, first, stride) ? (long_c - 1) : long_c;
    return acc;
  endfunction

endpackage

// File: rtl/txseq_edge.sv
module txseq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  // Resets high so that a level already high at reset release is not an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/txseq_cadence.sv
module txseq_cadence #(
  parameter int NUM_BITS     = 360,
  parameter int GROUP_BITS   = 37,
  parameter int LONG_CLKS    = 4,
  parameter int SHORT_FIRST  = 10,
  parameter int SHORT_STRIDE = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic arm_i,
  output logic bit_start_o,
  output logic last_end_o
);
  localparam int CNT_W = (LONG_CLKS > 2) ? $clog2(LONG_CLKS) : 1;
  localparam int POS_W = (GROUP_BITS > 2) ? $clog2(GROUP_BITS) : 1;
  localparam int IDX_W = (NUM_BITS > 2) ? $clog2(NUM_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_CLKS - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(LONG_CLKS - 2);
  localparam logic [POS_W-1:0] POS_WRAP   = POS_W'(GROUP_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(NUM_BITS - 1);

  logic             running_q;
  logic [CNT_W-1:0] cnt_q;
  logic [POS_W-1:0] pos_q;
  logic [IDX_W-1:0] idx_q;
  logic             short_w;
  logic             bit_end_w;

  assign short_w     = txseq_pkg::is_short(32'(pos_q), SHORT_FIRST, SHORT_STRIDE);
  assign bit_end_w   = running_q && (cnt_q == (short_w ? LAST_SHORT : LAST_LONG));
  assign bit_start_o = running_q && (cnt_q == '0);
  assign last_end_o  = bit_end_w && (idx_q == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      pos_q     <= '0;
      idx_q     <= '0;
    end else if (arm_i) begin
      running_q <= 1'b1;
      cnt_q     <= '0;
      pos_q     <= '0;
      idx_q     <= '0;
    end else if (running_q) begin
      if (bit_end_w) begin
        cnt_q <= '0;
        if (idx_q == IDX_LAST) begin
          running_q <= 1'b0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
          pos_q <= (pos_q == POS_WRAP) ? '0 : pos_q + POS_W'(1);
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/txseq_window.sv
module txseq_window #(
  parameter int INS_OFFSET = 275,
  parameter int LINE_CLKS  = 1402,
  parameter int DLY_W      = 4,
  parameter int TICK_W     = 11
) (
  input  logic              active_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic [DLY_W-1:0]  dly_i,
  output logic              open_o
);
  logic [TICK_W-1:0] lo_w;
  logic [TICK_W-1:0] hi_w;

  assign lo_w   = TICK_W'(INS_OFFSET) - TICK_W'(dly_i);
  assign hi_w   = lo_w + TICK_W'(LINE_CLKS);
  assign open_o = active_i && (tick_i >= lo_w) && (tick_i < hi_w);
endmodule

// File: rtl/txt_line_sequencer.sv
module txt_line_sequencer #(
  parameter int INS_OFFSET   = 275,
  parameter int NUM_BITS     = 360,
  parameter int GROUP_BITS   = 37,
  parameter int LONG_CLKS    = 4,
  parameter int SHORT_FIRST  = 10,
  parameter int SHORT_STRIDE = 9,
  parameter int DLY_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DLY_W-1:0] src_delay,
  input  logic             hsync,
  input  logic             serial_in,
  output logic             req_o,
  output logic             bit_o,
  output logic             bit_valid_o,
  output logic             line_done_o
);
  localparam int LINE_CLKS = int'(txseq_pkg::line_clocks(NUM_BITS, GROUP_BITS,
                                   LONG_CLKS, SHORT_FIRST, SHORT_STRIDE));
  localparam int TICK_END  = INS_OFFSET + LINE_CLKS;
  localparam int TICK_W    = $clog2(TICK_END + 1);
  localparam logic [TICK_W-1:0] TICK_SAT = TICK_W'(TICK_END);
  localparam logic [TICK_W-1:0] ARM_TICK = TICK_W'(INS_OFFSET - 1);

  // Named internal events, used by the bound checker.
  logic              sync_rise_w;
  logic              arm_w;
  logic              bit_start_w;
  logic              last_end_w;
  logic              open_w;

  logic              active_q;
  logic [TICK_W-1:0] tick_q;
  logic [DLY_W-1:0]  dly_q;
  logic              done_q;
  logic              valid_q;
  logic              data_q;

  txseq_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (hsync),
    .rise_o  (sync_rise_w)
  );

  // Line clock counter; enable and delay are captured only at the sync edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tick_q   <= '0;
      dly_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sync_rise_w) begin
        active_q <= enable;
        tick_q   <= '0;
        dly_q    <= src_delay;
      end else if (active_q) begin
        if (tick_q != TICK_SAT) tick_q <= tick_q + TICK_W'(1);
        if (last_end_w) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign arm_w = active_q && !sync_rise_w && (tick_q == ARM_TICK);

  txseq_cadence #(
    .NUM_BITS     (NUM_BITS),
    .GROUP_BITS   (GROUP_BITS),
    .LONG_CLKS    (LONG_CLKS),
    .SHORT_FIRST  (SHORT_FIRST),
    .SHORT_STRIDE (SHORT_STRIDE)
  ) u_cadence (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (sync_rise_w),
    .arm_i       (arm_w),
    .bit_start_o (bit_start_w),
    .last_end_o  (last_end_w)
  );

  txseq_window #(
    .INS_OFFSET (INS_OFFSET),
    .LINE_CLKS  (LINE_CLKS),
    .DLY_W      (DLY_W),
    .TICK_W     (TICK_W)
  ) u_window (
    .active_i (active_q),
    .tick_i   (tick_q),
    .dly_i    (dly_q),
    .open_o   (open_w)
  );

  // Sample the serial input on the first clock of every bit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= 1'b0;
    end else begin
      valid_q <= bit_start_w && !sync_rise_w;
      if (bit_start_w) data_q <= serial_in;
    end
  end

  assign req_o       = open_w;
  assign bit_o       = data_q;
  assign bit_valid_o = valid_q;
  assign line_done_o = done_q;
endmodule

// File: rtl/txt_line_sequencer_chk.sv
module txt_line_sequencer_chk #(
  parameter int NUM_BITS  = 360,
  parameter int LONG_CLKS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic req_o,
  input logic bit_valid_o,
  input logic line_done_o,
  input logic sync_rise,
  input logic bit_start
);
  logic [7:0]  gap_q;
  logic        seen_q;
  logic [15:0] nstrobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q     <= '0;
      seen_q    <= 1'b0;
      nstrobe_q <= '0;
    end else begin
      gap_q <= bit_valid_o ? 8'd1 : ((gap_q == 8'hFF) ? gap_q : gap_q + 8'd1);
      if (sync_rise) begin
        seen_q    <= 1'b0;
        nstrobe_q <= '0;
      end else if (bit_valid_o) begin
        seen_q    <= 1'b1;
        nstrobe_q <= nstrobe_q + 16'd1;
      end
    end
  end

  AST_GAP_SHORT_OR_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o && seen_q |-> (gap_q == 8'(LONG_CLKS) || gap_q == 8'(LONG_CLKS - 1))); // R3
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |=> !bit_valid_o); // R5
  AST_STROBE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    line_done_o |-> (nstrobe_q == 16'(NUM_BITS))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    line_done_o |=> !line_done_o); // R6
  AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    line_done_o |-> !req_o); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise && !enable |=> !req_o && !bit_start); // R7
endmodule

bind txt_line_sequencer txt_line_sequencer_chk #(
  .NUM_BITS  (NUM_BITS),
  .LONG_CLKS (LONG_CLKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .req_o       (req_o),
  .bit_valid_o (bit_valid_o),
  .line_done_o (line_done_o),
  .sync_rise   (sync_rise_w),
  .bit_start   (bit_start_w)
);

// File: tb/txt_line_sequencer_test.sv
module txt_line_sequencer_test;
  localparam int OFS   = 275;
  localparam int NB    = 360;
  localparam int TOTAL = 1402;
  localparam int LAST_M = 1685;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] src_delay = 4'd0;
  logic       hsync = 1'b0;
  logic       serial_in = 1'b0;
  logic       req_o, bit_o, bit_valid_o, line_done_o;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;
  bit  st_flag [TOTAL];
  int  len_obs [NB];

  always #2 clk = ~clk;

  txt_line_sequencer uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .src_delay(src_delay),
    .hsync(hsync), .serial_in(serial_in), .req_o(req_o), .bit_o(bit_o),
    .bit_valid_o(bit_valid_o), .line_done_o(line_done_o)
  );

  function automatic int exp_len(input int i);
    int p;
    p = (i % 37) + 1;
    return (p == 10 || p == 19 || p == 28 || p == 37) ? 3 : 4;
  endfunction

  function automatic bit pat(input int m, input int d);
    return (((m * 13) + (d * 5) + (m / 7)) % 5) < 2;
  endfunction

  task automatic chk(input bit ok, input string req, input string ctx,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, ctx, act, exp);
    end
  endtask

  task automatic run_line(input int d, input bit en, input int abort_at,
                          input bit wiggle, input string ctx);
    int  nstr = 0;
    int  last = -1;
    bit  prev = 0;
    @(negedge clk);
    hsync = 1'b1; enable = en; src_delay = 4'(d);
    for (int m = 0; m <= LAST_M; m++) begin
      bit e_req, e_val, e_done, nv;
      int k;
      @(negedge clk);
      if (m == 3) hsync = 1'b0;
      if (wiggle && m == 10) begin enable = ~en; src_delay = 4'(~d); end
      e_req  = en && (m >= OFS - d) && (m < OFS - d + TOTAL);
      k      = m - 1 - OFS;
      e_val  = en && k >= 0 && k < TOTAL && st_flag[k];
      e_done = en && (m == OFS + TOTAL);
      chk(req_o == e_req, "R2", ctx, int'(req_o), int'(e_req));
      chk(bit_valid_o == e_val, "R3", ctx, int'(bit_valid_o), int'(e_val));
      if (e_val && bit_valid_o) chk(bit_o == prev, "R5", ctx, int'(bit_o), int'(prev));
      chk(line_done_o == e_done, "R6", ctx, int'(line_done_o), int'(e_done));
      if (bit_valid_o) begin
        if (last >= 0 && nstr >= 1 && nstr <= NB) len_obs[nstr-1] = m - last;
        last = m;
        nstr++;
      end
      if (line_done_o && last >= 0 && nstr >= 1 && nstr <= NB) len_obs[nstr-1] = m - last + 1;
      nv = pat(m, d);
      serial_in = nv;
      prev = nv;
      if (m == abort_at) return;
    end
    if (en) begin
      int tot = 0;
      chk(nstr == NB, "R5", ctx, nstr, NB);
      if (nstr == NB) begin
        for (int i = 0; i < NB; i++) begin
          chk(len_obs[i] == exp_len(i), "R3", ctx, len_obs[i], exp_len(i));
          tot += len_obs[i];
        end
        for (int g = 0; g < NB / 37; g++) begin
          int s = 0;
          for (int j = 0; j < 37; j++) s += len_obs[g*37 + j];
          chk(s == 144, "R4", ctx, s, 144);
        end
        chk(tot == TOTAL, "R4", ctx, tot, TOTAL);
      end
    end else begin
      chk(nstr == 0, "R7", ctx, nstr, 0);
    end
  endtask

  task automatic summary;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int off = 0;
    for (int i = 0; i < NB; i++) begin
      st_flag[off] = 1'b1;
      off += exp_len(i);
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!req_o && !bit_valid_o && !line_done_o, "R1", "in reset",
        int'({req_o, bit_valid_o, line_done_o}), 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!req_o && !bit_valid_o && !line_done_o, "R1", "after reset",
          int'({req_o, bit_valid_o, line_done_o}), 0);
    end

    // R2 R3 R4 R5 R6: every delay setting
    for (int d = 0; d < 16; d++) run_line(d, 1'b1, -1, 1'b0, "delay sweep");

    // R7: disabled line
    run_line(7, 1'b0, -1, 1'b0, "R7 disabled");

    // R8: enable and delay changed mid-line
    run_line(3, 1'b1, -1, 1'b1, "R8 mid-line change");

    // R9: abort during bits, restart enabled
    run_line(9, 1'b1, 800, 1'b0, "R9 aborted line");
    run_line(2, 1'b1, -1, 1'b0, "R9 restarted line");

    // R9: abort during the lead-in, restart disabled
    run_line(4, 1'b1, 150, 1'b0, "R9 aborted lead-in");
    run_line(4, 1'b0, -1, 1'b0, "R9 restart disabled");

    repeat (5) @(negedge clk);
    summary();
  end
endmodule